// File: doc/BRIEF.md
# LCD Panel Raster Timing Generator

This block generates the raster timing for a parallel-RGB LCD panel that shows 800x480 pixels and is clocked at about 33 MHz. It runs from the pixel clock and a reset. Two counters walk a raster: one counts clocks within a line and one counts lines within a frame. From the counter state the block derives active-low horizontal and vertical sync, a data-enable flag, the column and row of the current visible pixel, and the colour bus.

Each axis places its blanking in the same way. The sync pulse starts the line or frame, and the first visible pixel or line follows at a fixed offset from that sync edge. The sync pulse lies inside this offset. The front porch fills the rest of the total.

During the visible window the colour input passes straight through. During blanking the colour outputs are forced to black. All outputs come from one register stage, so they change together on the same clock edge. Every timing value is an elaboration-time parameter, which lets the corner timings be simulated. The defaults give the typical point of a 1056-clock line and a 525-line frame.

Top module: `lcdr_raster_gen`

## Requirements
- R1: While reset is asserted, both sync outputs are high (inactive), data-enable is low, column and row are 0, and the colour outputs are 0.
- R2: A line lasts H_TOTAL clocks. The horizontal sync output is low for the first H_SYNC clocks of every line and high for the rest of the line.
- R3: The line counter advances only when the clock counter wraps, and a frame lasts V_TOTAL lines. The vertical sync output is low during lines 0 to V_SYNC-1 and changes only on the clock where a line starts.
- R4: Data-enable is high only when the line position is in [H_START, H_START+H_ACTIVE) and the frame position is in [V_START, V_START+V_ACTIVE), both counted from the leading sync edge.
- R5: While data-enable is high, column equals the line position minus H_START, and row equals the frame position minus V_START. While data-enable is low, both are 0.
- R6: The 24-bit colour input (red in bits 23:16, green in 15:8, blue in 7:0) is registered to the colour outputs on the same edge that raises data-enable. The colour outputs are 0 whenever data-enable is low.
- R7: All outputs leave one register stage after the counter state. After reset is released, the first clock edge shows line position 0 and frame position 0. The first pixel of a line appears exactly H_START clocks after horizontal sync falls.
- R8: With default parameters the raster is 1056x525 clocks and lines. The first visible line is line 23, the first visible pixel is at clock 46 of that line, and a visible line holds 800 data-enable clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 3*CH_W | Colour data for the current pixel |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| de_o | output | 1 | High during the visible window |
| col_o | output | COL_W | Visible column, 0 outside the window |
| row_o | output | ROW_W | Visible row, 0 outside the window |
| rgb_o | output | 3*CH_W | Colour output, black in blanking |

## Verification
A small raster (16x12) runs for many full frames. Its colour input changes on every clock, so a slip of one cycle, a swapped channel, or colour leaking into blanking each shows up as a difference on rgb_o. A second instance with the default parameters runs past its first visible line. This shows that the real offsets, porches and wrap points are correct and cannot be hidden by the small geometry. The spacing from the falling edge of horizontal sync to the first data-enable separates a sync placed at the wrong end of blanking from a correct one.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;
   // number of colour channels on the pixel bus (red, green, blue)
   localparam int unsigned NUM_CH = 3;

   // smallest width able to hold the values 0 .. n-1, never below one bit
   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/lcdr_axis.sv
module lcdr_axis
   import lcdr_pkg::*;
#(
   parameter int unsigned TOTAL  = 1056,
   parameter int unsigned SYNC   = 20,
   parameter int unsigned START  = 46,
   parameter int unsigned ACTIVE = 800,
   parameter int unsigned PW     = idx_width(ACTIVE)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          adv_i,
   output logic          wrap_o,
   output logic          sync_o,
   output logic          win_o,
   output logic [PW-1:0] pos_o
);
   localparam int unsigned CW   = idx_width(TOTAL);
   localparam int unsigned STOP = START + ACTIVE;

   if (SYNC < 1 || SYNC > START) begin : g_bad_sync
      $error("sync width must be at least 1 and no larger than the start offset");
   end
   if (STOP > TOTAL) begin : g_bad_total
      $error("total period too short for start offset plus active area");
   end

   logic [CW-1:0] cnt_q;

   assign wrap_o = adv_i && (cnt_q == CW'(TOTAL - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (wrap_o)  cnt_q <= '0;
      else if (adv_i)   cnt_q <= cnt_q + 1'b1;
   end

   assign sync_o = (cnt_q < CW'(SYNC));
   assign win_o  = (cnt_q >= CW'(START)) && (cnt_q < CW'(STOP));
   assign pos_o  = win_o ? PW'(cnt_q - CW'(START)) : '0;

   AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CW'(TOTAL - 1)); // R2
   AST_WRAP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> (cnt_q == '0)); // R2
   AST_HOLD_NO_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adv_i |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/lcdr_out_stage.sv
module lcdr_out_stage
   import lcdr_pkg::*;
#(
   parameter int unsigned CH_W  = 8,
   parameter int unsigned COL_W = 10,
   parameter int unsigned ROW_W = 9
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     h_sync_i,
   input  logic                     v_sync_i,
   input  logic                     h_win_i,
   input  logic                     v_win_i,
   input  logic [COL_W-1:0]         col_i,
   input  logic [ROW_W-1:0]         row_i,
   input  logic [NUM_CH*CH_W-1:0]   pix_i,
   output logic                     hsync_no,
   output logic                     vsync_no,
   output logic                     de_o,
   output logic [COL_W-1:0]         col_o,
   output logic [ROW_W-1:0]         row_o,
   output logic [NUM_CH*CH_W-1:0]   rgb_o
);
   logic vis;
   assign vis = h_win_i && v_win_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hsync_no <= 1'b1;
         vsync_no <= 1'b1;
         de_o     <= 1'b0;
         col_o    <= '0;
         row_o    <= '0;
      end else begin
         hsync_no <= ~h_sync_i;
         vsync_no <= ~v_sync_i;
         de_o     <= vis;
         col_o    <= vis ? col_i : '0;
         row_o    <= vis ? row_i : '0;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      logic [CH_W-1:0] chan_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chan_q <= '0;
         else         chan_q <= vis ? pix_i[c*CH_W +: CH_W] : '0;
      end
      assign rgb_o[c*CH_W +: CH_W] = chan_q;
   end

   AST_BLANK_IS_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !de_o |-> (rgb_o == '0)); // R6
   AST_COL_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (de_o && $past(de_o)) |-> (col_o == $past(col_o) + 1'b1)); // R5
   AST_POS_ZERO_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !de_o |-> (col_o == '0 && row_o == '0)); // R5
endmodule

// File: rtl/lcdr_raster_gen.sv
module lcdr_raster_gen
   import lcdr_pkg::*;
#(
   parameter int unsigned H_ACTIVE = 800,
   parameter int unsigned H_START  = 46,
   parameter int unsigned H_SYNC   = 20,
   parameter int unsigned H_TOTAL  = 1056,
   parameter int unsigned V_ACTIVE = 480,
   parameter int unsigned V_START  = 23,
   parameter int unsigned V_SYNC   = 10,
   parameter int unsigned V_TOTAL  = 525,
   parameter int unsigned CH_W     = 8,
   parameter int unsigned COL_W    = idx_width(H_ACTIVE),
   parameter int unsigned ROW_W    = idx_width(V_ACTIVE)
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [NUM_CH*CH_W-1:0] pix_i,
   output logic                   hsync_no,
   output logic                   vsync_no,
   output logic                   de_o,
   output logic [COL_W-1:0]       col_o,
   output logic [ROW_W-1:0]       row_o,
   output logic [NUM_CH*CH_W-1:0] rgb_o
);
   localparam int unsigned H_SYNC_MAX = 40;
   localparam int unsigned V_SYNC_MAX = 20;

   if (H_SYNC > H_SYNC_MAX) begin : g_bad_hsync
      $error("horizontal sync pulse exceeds panel limit");
   end
   if (V_SYNC > V_SYNC_MAX) begin : g_bad_vsync
      $error("vertical sync pulse exceeds panel limit");
   end

   logic             h_wrap, h_sync, h_win;
   logic             v_wrap, v_sync, v_win;
   logic [COL_W-1:0] h_pos;
   logic [ROW_W-1:0] v_pos;

   lcdr_axis #(
      .TOTAL(H_TOTAL), .SYNC(H_SYNC), .START(H_START), .ACTIVE(H_ACTIVE), .PW(COL_W)
   ) i_h_axis (
      .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(1'b1),
      .wrap_o(h_wrap), .sync_o(h_sync), .win_o(h_win), .pos_o(h_pos)
   );

   lcdr_axis #(
      .TOTAL(V_TOTAL), .SYNC(V_SYNC), .START(V_START), .ACTIVE(V_ACTIVE), .PW(ROW_W)
   ) i_v_axis (
      .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(h_wrap),
      .wrap_o(v_wrap), .sync_o(v_sync), .win_o(v_win), .pos_o(v_pos)
   );

   lcdr_out_stage #(
      .CH_W(CH_W), .COL_W(COL_W), .ROW_W(ROW_W)
   ) i_out (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .h_sync_i(h_sync), .v_sync_i(v_sync), .h_win_i(h_win), .v_win_i(v_win),
      .col_i(h_pos), .row_i(v_pos), .pix_i(pix_i),
      .hsync_no(hsync_no), .vsync_no(vsync_no), .de_o(de_o),
      .col_o(col_o), .row_o(row_o), .rgb_o(rgb_o)
   );

   AST_VS_AT_LINE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(vsync_no) |-> $fell(hsync_no)); // R3
   AST_NO_DE_IN_HSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hsync_no |-> !de_o); // R4
   AST_NO_DE_IN_VSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vsync_no |-> !de_o); // R4
   AST_FRAME_WRAP_ON_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_wrap |-> h_wrap); // R3
endmodule

// File: tb/test_lcdr_raster_gen.sv
module test_lcdr_raster_gen;
   // small raster for full-frame coverage
   localparam int HA = 8, HS = 4, HP = 2, HT = 16;
   localparam int VA = 6, VS = 3, VP = 2, VT = 12;
   // default raster
   localparam int DHA = 800, DHS = 46, DHP = 20, DHT = 1056;
   localparam int DVA = 480, DVS = 23, DVP = 10, DVT = 525;
   localparam int RUN = 25200;
   localparam int WATCHDOG_CYC = 60000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [23:0] pix = '0;
   always #2.5 clk = ~clk;

   logic hs_s, vs_s, de_s; logic [2:0] col_s, row_s; logic [23:0] rgb_s;
   logic hs_d, vs_d, de_d; logic [9:0] col_d; logic [8:0] row_d; logic [23:0] rgb_d;

   lcdr_raster_gen #(
      .H_ACTIVE(HA), .H_START(HS), .H_SYNC(HP), .H_TOTAL(HT),
      .V_ACTIVE(VA), .V_START(VS), .V_SYNC(VP), .V_TOTAL(VT)
   ) i_lcdr_raster_gen (
      .clk_i(clk), .rst_ni(rst_n), .pix_i(pix),
      .hsync_no(hs_s), .vsync_no(vs_s), .de_o(de_s),
      .col_o(col_s), .row_o(row_s), .rgb_o(rgb_s)
   );

   lcdr_raster_gen i_lcdr_raster_gen_dflt (
      .clk_i(clk), .rst_ni(rst_n), .pix_i(pix),
      .hsync_no(hs_d), .vsync_no(vs_d), .de_o(de_d),
      .col_o(col_d), .row_o(row_d), .rgb_o(rgb_d)
   );

   typedef struct { int p; logic [23:0] px; } item_t;
   item_t sb_q[$];

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [23:0] mk_pix(input int p);
      logic [31:0] u;
      u = p;
      return {u[7:0], u[15:8] ^ 8'hA5, ~u[7:0]};
   endfunction

   // driver: sets the colour input for the next edge and queues what that edge must show
   task automatic drive_one(input int p);
      item_t it;
      pix = mk_pix(p);
      it.p = p; it.px = pix;
      sb_q.push_back(it);
   endtask

   // monitor state
   logic prev_hs = 1'b1, prev_de = 1'b0;
   int since_fall = 0;
   int de_cnt_d = 0;
   bit first_d_seen = 0;

   always begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
         item_t it;
         int h, v, dh, dv;
         bit vis, dvis;
         it = sb_q.pop_front();
         // small raster
         h = it.p % HT; v = (it.p / HT) % VT;
         vis = (h >= HS && h < HS + HA && v >= VS && v < VS + VA);
         chk("R2", "hsync", hs_s, !(h < HP));
         chk("R3", "vsync", vs_s, !(v < VP));
         chk("R4", "de", de_s, vis);
         chk("R5", "col", col_s, vis ? h - HS : 0);
         chk("R5", "row", row_s, vis ? v - VS : 0);
         chk("R6", "rgb", rgb_s, vis ? it.px : 24'h0);
         // R7: first pixel of a line H_START clocks after hsync falls
         if (prev_hs && !hs_s) since_fall = 0; else since_fall++;
         if (de_s && !prev_de) chk("R7", "sync-to-pixel", since_fall, HS);
         prev_hs = hs_s; prev_de = de_s;
         // default raster (R8)
         dh = it.p % DHT; dv = (it.p / DHT) % DVT;
         dvis = (dh >= DHS && dh < DHS + DHA && dv >= DVS && dv < DVS + DVA);
         if (hs_d != !(dh < DHP) || vs_d != !(dv < DVP) || de_d != dvis ||
             col_d != (dvis ? dh - DHS : 0) || row_d != (dvis ? dv - DVS : 0) ||
             rgb_d != (dvis ? it.px : 24'h0)) begin
            chk("R8", "default raster", {hs_d, vs_d, de_d, col_d, row_d},
                {!(dh < DHP), !(dv < DVP), dvis, 10'(dvis ? dh - DHS : 0), 9'(dvis ? dv - DVS : 0)});
            chk("R8", "default rgb", rgb_d, dvis ? it.px : 24'h0);
         end else n_chk++;
         if (de_d) begin
            de_cnt_d++;
            if (!first_d_seen) begin
               first_d_seen = 1;
               chk("R8", "first visible position", it.p, DVS * DHT + DHS);
            end
         end
      end
   end

   task automatic report;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(WATCHDOG_CYC * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "hsync", hs_s, 1); chk("R1", "vsync", vs_s, 1);
      chk("R1", "de", de_s, 0);   chk("R1", "col/row", {col_s, row_s}, 0);
      chk("R1", "rgb", rgb_s, 0); chk("R1", "default outputs", {hs_d, vs_d, de_d, col_d, row_d, rgb_d}, {2'b11, 44'h0});
      rst_n = 1'b1;
      for (int p = 0; p < RUN; p++) begin
         drive_one(p);
         @(negedge clk);
      end
      @(negedge clk);
      chk("R8", "visible clocks in first line", de_cnt_d, DHA);
      chk("R8", "first pixel seen", first_d_seen, 1);
      done = 1;
      report();
   end
endmodule